// File: doc/BRIEF.md
# MMU Fault Status Capture Register

This block holds the record of the most recent address-translation fault so that trap software can find out what went wrong. When the fault logic pulses its strobe, the block builds a status word from several inputs: the translation mode in force, the kind of access, the privilege state, whether the processor was already inside a trap, and a vector of fault-type bits from the detector. In the same cycle it latches the faulting virtual address into a separate address register. Unaligned-access faults use the same strobe, so their address is captured in the same way.

The status word carries a valid bit. If a new fault arrives while that bit is still set, the new word also carries an overwrite bit, which tells software that an earlier record was lost. Software reads the word and the address directly from the output ports. It writes the word through a write strobe, and a write of zero rearms the block. A fault strobe in the same cycle as a software write takes precedence over the write.

Top module: `fsr_capture`

## Requirements
- R1: One clock edge after `flt_stb`, bit 0 (valid) of `fsr_word` is 1.
- R2: Bits [3:2] of a captured word hold the context class, derived from `flt_mode` (0 physical, 1 user primary, 2 kernel primary, 3 user secondary, 4 kernel secondary, 5 to 7 nucleus). The class codes are: 0 primary for modes 1 and 2, 1 secondary for modes 3 and 4, 2 nucleus for modes 5 to 7, and 3 no-translation for mode 0.
- R3: An instruction fetch (`flt_acc` = 2) with `flt_tl_nz` = 1 writes class 2 (nucleus) into bits [3:2], whatever the mode.
- R4: Bit 4 (write) is 1 only for a store (`flt_acc` = 1). Bit 5 (non-faulting) is 1 only for a non-faulting load (`flt_acc` = 3). A plain load (`flt_acc` = 0) and a fetch set neither bit.
- R5: Bit 6 of a captured word equals `flt_priv` at the strobe.
- R6: Bits [FT_W+6:7] of a captured word equal `flt_type` at the strobe.
- R7: Bit 1 (overwrite) of a captured word is 1 exactly when bit 0 of `fsr_word` was 1 in the cycle of the strobe.
- R8: One clock edge after every `flt_stb`, `far_addr` equals the `flt_va` presented with it.
- R9: When `sw_wr` is 1 without a strobe, `fsr_word` becomes `sw_wdata` one edge later. Writing zero clears the valid and overwrite bits, so the next fault has bit 1 at 0. `far_addr` does not change.
- R10: When `flt_stb` and `sw_wr` are both 1 in the same cycle, the fault word is captured and the write is discarded. The overwrite bit then reflects the word as it was before that edge.
- R11: With neither `flt_stb` nor `sw_wr` set, `fsr_word` and `far_addr` hold their values, and reset drives both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_stb | input | 1 | Fault capture strobe |
| flt_mode | input | 3 | Translation mode at the fault |
| flt_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 non-faulting load |
| flt_priv | input | 1 | Processor in privileged state |
| flt_tl_nz | input | 1 | Trap level above zero |
| flt_type | input | FT_W | Fault-type bits from the detector |
| flt_va | input | VA_W | Faulting virtual address |
| sw_wr | input | 1 | Software write strobe for the status word |
| sw_wdata | input | FT_W+7 | Software write data |
| fsr_word | output | FT_W+7 | Fault status word |
| far_addr | output | VA_W | Fault address |

## Verification
Every result of this block appears exactly one clock edge after its stimulus: a captured word, a captured address, a software write and the outcome of a collision all show up at the next rising edge, and nothing combinational reaches the outputs. The bench drives inputs at the falling edge and compares the outputs at the following falling edge, half a period after the capturing edge. Idle cycles are checked at that same point for unchanged values. The sweep clears the word before each fault so that the overwrite bit has a known expected value. A separate sequence chains faults with no clear in between to check the overwrite path.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NFLD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CTX_PRI  = 2'd0,
        CTX_SEC  = 2'd1,
        CTX_NUC  = 2'd2,
        CTX_NOXL = 2'd3
    } ctx_cls_e;

    localparam logic [2:0] MODE_PHYS    = 3'd0;
    localparam logic [2:0] MODE_USR_PRI = 3'd1;
    localparam logic [2:0] MODE_KRN_PRI = 3'd2;
    localparam logic [2:0] MODE_USR_SEC = 3'd3;
    localparam logic [2:0] MODE_KRN_SEC = 3'd4;

    localparam int HDR_W = 7;

    typedef struct packed {
        logic     priv;
        logic     nf;
        logic     wr;
        ctx_cls_e ctx;
        logic     ovw;
        logic     vld;
    } fsr_hdr_t;

    function automatic ctx_cls_e classify(input logic [2:0] mode,
                                          input acc_kind_e acc,
                                          input logic tl_nz);
        ctx_cls_e c;
        unique case (mode)
            MODE_PHYS:                  c = CTX_NOXL;
            MODE_USR_PRI, MODE_KRN_PRI: c = CTX_PRI;
            MODE_USR_SEC, MODE_KRN_SEC: c = CTX_SEC;
            default:                    c = CTX_NUC;
        endcase
        if (acc == ACC_FETCH && tl_nz) begin
            c = CTX_NUC;
        end
        return c;
    endfunction

endpackage

// File: rtl/fsr_encode.sv
module fsr_encode
    import fsr_pkg::*;
#(
    parameter int FT_W = 6
) (
    input  logic [2:0]        mode,
    input  logic [1:0]        acc,
    input  logic              priv,
    input  logic              tl_nz,
    input  logic [FT_W-1:0]   ftype,
    input  logic              prev_vld,
    output logic [FT_W+HDR_W-1:0] word
);
    acc_kind_e acc_k;
    fsr_hdr_t  hdr;

    always_comb begin
        acc_k    = acc_kind_e'(acc);
        hdr.vld  = 1'b1;
        hdr.ovw  = prev_vld;
        hdr.ctx  = classify(mode, acc_k, tl_nz);
        hdr.wr   = (acc_k == ACC_STORE);
        hdr.nf   = (acc_k == ACC_NFLD);
        hdr.priv = priv;
        word     = {ftype, hdr};
    end

    // R3: a fetch inside a trap always reports the nucleus class
    always_comb begin
        if (acc_k == ACC_FETCH && tl_nz) begin
            assert_fetch_nucleus_R3: assert (word[3:2] == CTX_NUC);
        end
        // R4: write and non-faulting never appear together
        assert_wr_nf_exclusive_R4: assert ($onehot0(word[5:4]));
    end
endmodule

// File: rtl/fsr_store.sv
module fsr_store #(
    parameter int WORD_W = 13,
    parameter int VA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [WORD_W-1:0] cap_word,
    input  logic [VA_W-1:0]   cap_va,
    input  logic              sw_wr,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] word_q,
    output logic [VA_W-1:0]   va_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            va_q   <= '0;
        end else if (cap) begin
            word_q <= cap_word;
            va_q   <= cap_va;
        end else if (sw_wr) begin
            word_q <= sw_wdata;
        end
    end

    assert_valid_after_fault_R1: assert property (@(posedge clk) disable iff (rst)
        cap |=> word_q[0]);
    assert_overwrite_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (cap && word_q[0]) |=> word_q[1]);
    assert_addr_capture_R8: assert property (@(posedge clk) disable iff (rst)
        cap |=> (va_q == $past(cap_va)));
    assert_sw_write_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !cap) |=> (word_q == $past(sw_wdata) && $stable(va_q)));
    assert_fault_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && cap) |=> word_q[0]);
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr && !cap) |=> ($stable(word_q) && $stable(va_q)));
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture
    import fsr_pkg::*;
#(
    parameter int FT_W = 6,
    parameter int VA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flt_stb,
    input  logic [2:0]            flt_mode,
    input  logic [1:0]            flt_acc,
    input  logic                  flt_priv,
    input  logic                  flt_tl_nz,
    input  logic [FT_W-1:0]       flt_type,
    input  logic [VA_W-1:0]       flt_va,
    input  logic                  sw_wr,
    input  logic [FT_W+6:0]       sw_wdata,
    output logic [FT_W+6:0]       fsr_word,
    output logic [VA_W-1:0]       far_addr
);
    localparam int WORD_W = FT_W + HDR_W;

    logic [WORD_W-1:0] new_word;

    fsr_encode #(.FT_W(FT_W)) u_enc (
        .mode     (flt_mode),
        .acc      (flt_acc),
        .priv     (flt_priv),
        .tl_nz    (flt_tl_nz),
        .ftype    (flt_type),
        .prev_vld (fsr_word[0]),
        .word     (new_word)
    );

    fsr_store #(.WORD_W(WORD_W), .VA_W(VA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cap      (flt_stb),
        .cap_word (new_word),
        .cap_va   (flt_va),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .word_q   (fsr_word),
        .va_q     (far_addr)
    );
endmodule

// File: tb/test_fsr_capture.sv
module test_fsr_capture;
    localparam int FT_W = 6;
    localparam int VA_W = 32;
    localparam int WW   = FT_W + 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flt_stb = 1'b0;
    logic [2:0] flt_mode = '0;
    logic [1:0] flt_acc = '0;
    logic flt_priv = 1'b0;
    logic flt_tl_nz = 1'b0;
    logic [FT_W-1:0] flt_type = '0;
    logic [VA_W-1:0] flt_va = '0;
    logic sw_wr = 1'b0;
    logic [WW-1:0] sw_wdata = '0;
    logic [WW-1:0] fsr_word;
    logic [VA_W-1:0] far_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fsr_capture #(.FT_W(FT_W), .VA_W(VA_W)) i_fsr_capture (
        .clk(clk), .rst(rst), .flt_stb(flt_stb), .flt_mode(flt_mode),
        .flt_acc(flt_acc), .flt_priv(flt_priv), .flt_tl_nz(flt_tl_nz),
        .flt_type(flt_type), .flt_va(flt_va), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .fsr_word(fsr_word), .far_addr(far_addr)
    );

    always #10 clk = ~clk;

    function automatic logic [WW-1:0] exp_word(input int mode, input int acc,
        input int priv, input int tl, input int ft, input int prev);
        int ctx;
        if (acc == 2 && tl == 1) ctx = 2;
        else if (mode == 0) ctx = 3;
        else if (mode <= 2) ctx = 0;
        else if (mode <= 4) ctx = 1;
        else ctx = 2;
        return WW'(ft * 128 + priv * 64 + (acc == 3 ? 32 : 0) + (acc == 1 ? 16 : 0)
                   + ctx * 4 + prev * 2 + 1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        flt_stb = 1'b0;
        sw_wr   = 1'b0;
    endtask

    task automatic fault(input int mode, input int acc, input int priv,
                         input int tl, input int ft, input logic [VA_W-1:0] va);
        flt_stb = 1'b1; flt_mode = 3'(mode); flt_acc = 2'(acc);
        flt_priv = priv[0]; flt_tl_nz = tl[0]; flt_type = FT_W'(ft); flt_va = va;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [VA_W-1:0] va;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset word", 64'(fsr_word), 64'd0);
        chk("R11 reset addr", 64'(far_addr), 64'd0);

        // Sweep R1-style capture over all modes, kinds, privilege and trap level
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 4; a++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int t = 0; t < 2; t++) begin
                        int ft;
                        ft = (m * 16 + a * 4 + p * 2 + t) % 64;
                        va = 32'h1000_0000 + 32'(m * 65536 + a * 4096 + p * 16 + t * 4 + 3);
                        sw_wr = 1'b1; sw_wdata = '0;
                        step();
                        fault(m, a, p, t, ft, va);
                        step();
                        // R1 R2 R3 R4 R5 R6 checked through the full word
                        chk("R1/R2/R3/R4/R5/R6 word", 64'(fsr_word),
                            64'(exp_word(m, a, p, t, ft, 0)));
                        chk("R8 addr", 64'(far_addr), 64'(va));
                    end
                end
            end
        end

        // R3: fetch in trap with physical mode still reports nucleus
        sw_wr = 1'b1; sw_wdata = '0; step();
        fault(0, 2, 0, 1, 5, 32'hABCD_0001); step();
        chk("R3 fetch nucleus ctx", 64'(fsr_word[3:2]), 64'd2);

        // R7: chained faults without a clear
        fault(3, 1, 1, 0, 9, 32'h0000_1111); step();
        chk("R7 overwrite set", 64'(fsr_word), 64'(exp_word(3, 1, 1, 0, 9, 1)));
        fault(1, 0, 0, 0, 63, 32'h0000_2222); step();
        chk("R7 overwrite again", 64'(fsr_word), 64'(exp_word(1, 0, 0, 0, 63, 1)));
        chk("R8 latest addr", 64'(far_addr), 64'h2222);

        // R9: write of zero clears, address untouched, next fault not flagged
        sw_wr = 1'b1; sw_wdata = '0; step();
        chk("R9 clear word", 64'(fsr_word), 64'd0);
        chk("R9 addr kept", 64'(far_addr), 64'h2222);
        fault(4, 3, 0, 0, 2, 32'h0000_3333); step();
        chk("R9 no overwrite after clear", 64'(fsr_word[1]), 64'd0);
        sw_wr = 1'b1; sw_wdata = WW'(13'h0A5C); step();
        chk("R9 nonzero write", 64'(fsr_word), 64'h0A5C);

        // R10: collision while valid is set -> fault wins, overwrite from old word
        sw_wr = 1'b1; sw_wdata = WW'(1); step();
        sw_wr = 1'b1; sw_wdata = '0;
        fault(2, 1, 1, 0, 7, 32'h0000_4444); step();
        chk("R10 fault wins over write", 64'(fsr_word), 64'(exp_word(2, 1, 1, 0, 7, 1)));
        chk("R10 addr", 64'(far_addr), 64'h4444);
        // R10: collision with an old cleared word and a write that sets valid
        sw_wr = 1'b1; sw_wdata = '0; step();
        sw_wr = 1'b1; sw_wdata = WW'(3);
        fault(5, 0, 0, 0, 1, 32'h0000_5555); step();
        chk("R10 overwrite from old word", 64'(fsr_word), 64'(exp_word(5, 0, 0, 0, 1, 0)));

        // R11: idle cycles with moving inputs hold the outputs
        for (int i = 0; i < 5; i++) begin
            flt_mode = 3'(i); flt_va = 32'(i * 77); sw_wdata = WW'(i * 99);
            step();
            chk("R11 hold word", 64'(fsr_word), 64'(exp_word(5, 0, 0, 0, 1, 0)));
            chk("R11 hold addr", 64'(far_addr), 64'h5555);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule